// File: doc/BRIEF.md
# Quarter-Wave Sine Synthesizer Core

This block is a numerically controlled oscillator that produces a sampled sine wave for an external DAC. A phase register advances by a programmable step on every clock and wraps around at its full range. The output frequency is therefore the clock frequency times the step divided by 2^PHASE_W, and a smaller step gives a lower frequency. The most significant phase bit is also driven out as a coarse square-wave clock.

Only the first quarter of a sine period is stored. The phase is cut down to its top bits, which form a quadrant pair and a table index. In the second and fourth quarters the index is mirrored by complementing it. In the second half of the period the table reading is bitwise inverted, so the output falls below mid-scale. The output is offset binary, and a single narrow table replaces two full half-wave tables.

A new step value is captured into a holding register only when a load strobe is present. The table read is registered, and the half-period bit is delayed by the same cycle so that the inversion stays aligned with its sample.

Top module: `dds_qwave_core`

## Requirements
- R1: Each clock the phase register adds the held step modulo 2^PHASE_W (default 17 bits). sq_o equals phase bit PHASE_W-1 as it stands after that clock edge.
- R2: tw_i is copied into the held step only on a clock edge where tw_load_i is 1. Changes on tw_i with tw_load_i at 0 leave the output sequence unchanged.
- R3: The table has 2^LUT_AW entries. Entry k holds round((2^(AMP_W-1)-1)·sin((k+0.5)·π/(2·2^LUT_AW))). The index is phase bits [PHASE_W-3 : PHASE_W-2-LUT_AW].
- R4: When phase bit PHASE_W-2 is 1, the index is the bitwise complement of those bits. Samples at mirrored positions within a half period (j and 2·2^LUT_AW-1-j) are therefore equal.
- R5: With phase bit PHASE_W-1 at 0 the output is {1, entry}. With it at 1 the output is the bitwise complement of {1, entry}. Two samples half a period apart sum to 2^AMP_W-1.
- R6: The output MSB is 1 for every first-half sample and 0 for every second-half sample.
- R7: While rst_ni is low, the phase and the held step are zero, dac_o is mid-scale (2^(AMP_W-1)) and sq_o is 0.
- R8: dac_o after a clock edge reflects the phase held before that edge, which is one register of latency.
- R9: After a step of zero has been loaded, the phase and sq_o stop changing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tw_i | input | PHASE_W | Step (tuning) value to load |
| tw_load_i | input | 1 | Capture tw_i into the held step |
| dac_o | output | AMP_W | Offset-binary sample for the DAC |
| sq_o | output | 1 | Phase MSB as a square clock |

## Verification
The timing counts from a load strobe sampled at rising edge k:
- At edge k the held step updates.
- At edge k+1 the phase first moves by the new step, and sq_o shows this after edge k+1.
- After edge k+2, dac_o shows the sample for that phase.

The bench keeps a reference phase and step that advance at rising edges, together with a one-deep copy of the previous phase. It compares both outputs at the falling edge against that reference. The first sample after reset release is expected at mid-scale until a rising edge has occurred. A single-index-step sweep records one full period by phase. The mirror and half-period sum properties are then checked on the observed samples.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam real PI = 3.14159265358979323846;

  // Quarter-wave magnitude for table entry k, centred on the half step
  function automatic int qsine(input int k, input int depth, input int amax);
    real th;
    th = (real'(k) + 0.5) * PI / (2.0 * real'(depth));
    return $rtoi(real'(amax) * $sin(th) + 0.5);
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 17,
  parameter int TOP_W   = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] tw_i,
  input  logic               load_i,
  output logic [TOP_W-1:0]   phase_top_o
);
  logic [PHASE_W-1:0] step_q, step_d;
  logic [PHASE_W-1:0] acc_q, acc_d;

  always_comb begin
    step_d = step_q;
    if (load_i) step_d = tw_i;
    acc_d = acc_q + step_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      acc_q  <= '0;
    end else begin
      step_q <= step_d;
      acc_q  <= acc_d;
    end
  end

  assign phase_top_o = acc_q[PHASE_W-1 -: TOP_W];
endmodule

// File: rtl/dds_addr_mirror.sv
module dds_addr_mirror #(
  parameter int LUT_AW = 8
) (
  input  logic [LUT_AW+1:0] phase_top_i,
  output logic [LUT_AW-1:0] addr_o,
  output logic              half_o
);
  logic quarter_odd;
  logic [LUT_AW-1:0] raw_idx;

  always_comb begin
    half_o      = phase_top_i[LUT_AW+1];
    quarter_odd = phase_top_i[LUT_AW];
    raw_idx     = phase_top_i[LUT_AW-1:0];
    addr_o      = raw_idx ^ {LUT_AW{quarter_odd}};
  end
endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
  parameter int LUT_AW = 8,
  parameter int MAG_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LUT_AW-1:0] addr_i,
  output logic [MAG_W-1:0]  mag_o
);
  localparam int DEPTH = 1 << LUT_AW;
  localparam int AMAX  = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] tbl [DEPTH];
  logic [MAG_W-1:0] mag_d, mag_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign tbl[g] = MAG_W'(dds_pkg::qsine(g, DEPTH, AMAX));
  end

  always_comb mag_d = tbl[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mag_q <= '0;
    else         mag_q <= mag_d;
  end

  assign mag_o = mag_q;
endmodule

// File: rtl/dds_amp_unfold.sv
module dds_amp_unfold #(
  parameter int AMP_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             half_i,
  input  logic [AMP_W-2:0] mag_i,
  output logic [AMP_W-1:0] dac_o
);
  logic half_q, half_d;
  logic [AMP_W-1:0] upper;

  always_comb half_d = half_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) half_q <= 1'b0;
    else         half_q <= half_d;
  end

  always_comb begin
    upper = {1'b1, mag_i};
    dac_o = upper ^ {AMP_W{half_q}};
  end
endmodule

// File: rtl/dds_qwave_core.sv
module dds_qwave_core #(
  parameter int PHASE_W = 17,
  parameter int LUT_AW  = 8,
  parameter int AMP_W   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [PHASE_W-1:0] tw_i,
  input  logic               tw_load_i,
  output logic [AMP_W-1:0]   dac_o,
  output logic               sq_o
);
  localparam int TOP_W = LUT_AW + 2;
  localparam int MAG_W = AMP_W - 1;

  logic [TOP_W-1:0]  phase_top;
  logic [LUT_AW-1:0] rom_addr;
  logic              half_now;
  logic [MAG_W-1:0]  mag;

  dds_phase_acc #(.PHASE_W(PHASE_W), .TOP_W(TOP_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .tw_i(tw_i), .load_i(tw_load_i),
    .phase_top_o(phase_top)
  );

  dds_addr_mirror #(.LUT_AW(LUT_AW)) u_mirror (
    .phase_top_i(phase_top), .addr_o(rom_addr), .half_o(half_now)
  );

  dds_quarter_rom #(.LUT_AW(LUT_AW), .MAG_W(MAG_W)) u_rom (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(rom_addr), .mag_o(mag)
  );

  dds_amp_unfold #(.AMP_W(AMP_W)) u_unfold (
    .clk_i(clk_i), .rst_ni(rst_ni), .half_i(half_now), .mag_i(mag),
    .dac_o(dac_o)
  );

  assign sq_o = half_now;
endmodule

// File: rtl/dds_qwave_checker.sv
module dds_qwave_checker #(
  parameter int PHASE_W = 17,
  parameter int AMP_W   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [PHASE_W-1:0] tw,
  input logic               load,
  input logic [AMP_W-1:0]   dac,
  input logic               sq
);
  localparam logic [AMP_W-1:0] MID = AMP_W'(1) << (AMP_W-1);

  // R6: a first-half phase yields an upper-half code one cycle later
  a_r6_first_half_high: assert property (@(posedge clk) disable iff (!rst_n)
    !sq |=> dac[AMP_W-1]);

  // R6: a second-half phase yields a lower-half code one cycle later
  a_r6_second_half_low: assert property (@(posedge clk) disable iff (!rst_n)
    sq |=> !dac[AMP_W-1]);

  // R7: reset holds mid-scale output and a low square clock
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r7_reset_mid: assert (dac == MID && !sq);
    end
  end

  // R9: a zero step, once held, freezes the phase MSB
  a_r9_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (load && tw == '0) ##1 !load |=> $stable(sq));
endmodule

bind dds_qwave_core dds_qwave_checker #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .tw(tw_i), .load(tw_load_i),
  .dac(dac_o), .sq(sq_o)
);

// File: tb/tb_dds_qwave_core.sv
module tb_dds_qwave_core;
  localparam int PHASE_W = 17;
  localparam int LUT_AW  = 8;
  localparam int AMP_W   = 12;
  localparam int DEPTH   = 1 << LUT_AW;
  localparam int SHIFT   = PHASE_W - 2 - LUT_AW;
  localparam int MID     = 1 << (AMP_W-1);
  localparam int FULL    = (1 << AMP_W) - 1;
  localparam real PI     = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic [PHASE_W-1:0] tw = '0;
  logic tw_load = 1'b0;
  logic [AMP_W-1:0] dac;
  logic sq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dds_qwave_core #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tw_i(tw), .tw_load_i(tw_load),
    .dac_o(dac), .sq_o(sq)
  );

  always #10 clk = ~clk;

  // Reference state, from the requirements
  logic [PHASE_W-1:0] m_tw, m_acc, m_prev;
  bit m_started;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tw <= '0; m_acc <= '0; m_prev <= '0; m_started <= 0;
    end else begin
      if (tw_load) m_tw <= tw;
      m_acc <= m_acc + m_tw;
      m_prev <= m_acc;
      m_started <= 1;
    end
  end

  function automatic int expf(input logic [PHASE_W-1:0] ph);
    int idx, mag, u;
    idx = int'(ph[PHASE_W-3 -: LUT_AW]);
    if (ph[PHASE_W-2]) idx = DEPTH - 1 - idx;
    mag = $rtoi(real'(MID-1) * $sin((real'(idx) + 0.5) * PI / (2.0 * DEPTH)) + 0.5);
    u = MID + mag;
    return ph[PHASE_W-1] ? (FULL - u) : u;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1, R3, R8: compare outputs with the reference at the falling edge
  task automatic cmp_model();
    int e;
    e = m_started ? expf(m_prev) : MID;
    chk(int'(dac) == e, "R8/R3 dac", int'(dac), e);
    chk(sq == m_acc[PHASE_W-1], "R1 sq", int'(sq), int'(m_acc[PHASE_W-1]));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tw_load = 1'b0;
    @(negedge clk);
    chk(int'(dac) == MID, "R7 dac mid", int'(dac), MID);
    chk(sq == 1'b0, "R7 sq low", int'(sq), 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic load_word(input logic [PHASE_W-1:0] w);
    tw = w; tw_load = 1'b1;
    @(negedge clk); cmp_model();
    tw_load = 1'b0;
  endtask

  int samp [4*DEPTH];

  initial begin
    void'($urandom(32'd7));
    #1 rst_n = 1'b0;
    do_reset();

    // R1/R2/R8: random words, sparse loads, tw_i toggling without a load
    for (int i = 0; i < 3000; i++) begin
      tw = PHASE_W'($urandom);
      tw_load = ($urandom % 16) == 0;
      @(negedge clk); cmp_model();
    end
    tw_load = 1'b0;

    // R2: load a word, then change tw_i freely without a strobe
    load_word(PHASE_W'(1000));
    for (int i = 0; i < 50; i++) begin
      tw = PHASE_W'($urandom);
      @(negedge clk); cmp_model();
    end

    // R1: wrap with the largest step
    load_word('1);
    for (int i = 0; i < 20; i++) begin @(negedge clk); cmp_model(); end

    // R9: zero step freezes phase and output
    load_word('0);
    @(negedge clk); cmp_model();
    @(negedge clk); cmp_model();
    begin
      logic [AMP_W-1:0] d0;
      logic s0;
      d0 = dac; s0 = sq;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        chk(dac == d0, "R9 dac frozen", int'(dac), int'(d0));
        chk(sq == s0, "R9 sq frozen", int'(sq), int'(s0));
      end
    end

    // R4/R5/R6: sweep one table index per clock over a full period
    do_reset();
    load_word(PHASE_W'(1) << SHIFT);
    for (int i = 0; i < 4*DEPTH + 8; i++) begin
      @(negedge clk); cmp_model();
      if (m_started) samp[int'(m_prev >> SHIFT)] = int'(dac);
    end
    for (int j = 0; j < DEPTH; j++) begin
      chk(samp[j] == samp[2*DEPTH-1-j], "R4 mirror", samp[j], samp[2*DEPTH-1-j]);
      chk(samp[j] + samp[j+2*DEPTH] == FULL, "R5 half sum",
          samp[j] + samp[j+2*DEPTH], FULL);
    end
    for (int j = 0; j < 2*DEPTH; j++) begin
      chk(samp[j] >= MID, "R6 upper half", samp[j], MID);
      chk(samp[j+2*DEPTH] < MID, "R6 lower half", samp[j+2*DEPTH], MID-1);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule